// File: doc/BRIEF.md
# Automatic Gain Control Stepper

This block keeps the 5-bit gain code shared by three measurement channels and moves it by at most one code per finished conversion. Each finished conversion arrives as one beat on a valid/ready stream that carries three signed 10-bit channel samples. The block classifies the beat as too weak, too strong or in range. It records the result as status bits and a warning flag. When automatic adjustment is enabled, it steps the gain one code in the direction that fixes the fault. The gain code drives the external amplifier, and a halved copy of it is exported for the angle word.

A host can load a new gain code at any time through a plain write strobe, and it can turn automatic stepping off. A host write always wins over a conversion in the same cycle. While the write strobe is high, `smp_ready` is low, so a pending conversion beat waits one cycle and is then judged against the newly written gain. At all other times, `smp_ready` is high out of reset. A beat transfers on a rising clock edge where `smp_valid` and `smp_ready` are both high. The source must hold `smp_data` stable while `smp_valid` is high and `smp_ready` is low.

Top module: `agc_stepper`

## Requirements
- R1: After reset, `gain_code` is 0, `gain_top` is 0, `status` bits 7..1 are 0 and `warn` is 0.
- R2: An accepted beat in which every channel magnitude is below 256 sets the underflow flag (status bit 2). With stepping enabled, it raises the gain code by 1 on the same edge.
- R3: An accepted beat in which any channel magnitude is above 506 sets the overflow flag (status bit 1). With stepping enabled, it lowers the gain code by 1. Overflow takes priority over underflow.
- R4: Magnitudes of exactly 256 and exactly 506 count as in range. A beat with no fault clears both flags and leaves the gain code unchanged.
- R5: The gain code saturates at 0 and 17 and never wraps. At a limit, the fault flag is still set.
- R6: With `agc_off` high, accepted beats still update the flags but leave the gain code unchanged.
- R7: A host write loads `host_gain` into the gain code on the next edge, whatever `agc_off` is. Values above 17 load as 17.
- R8: `smp_ready` is low in any cycle where `host_wr` is high, so no beat is taken in that cycle. The held beat is taken on the next ready edge and steps from the written gain.
- R9: `warn` is the OR of the underflow and overflow flags. Status bit 0 follows `conv_busy` directly, and status bits 7..3 are always 0.
- R10: `gain_top` equals the gain code shifted right by one.
- R11: On edges with no accepted beat and no host write, the gain code and both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A conversion result beat is offered |
| smp_ready | output | 1 | The block can take a beat (low during a host write) |
| smp_data | input | 30 | Channel c sample at bits [10c+9:10c], signed two's complement |
| agc_off | input | 1 | 1 turns automatic stepping off |
| conv_busy | input | 1 | A conversion is running; shown as status bit 0 |
| host_wr | input | 1 | Host gain write strobe |
| host_gain | input | 5 | Gain value for a host write |
| gain_code | output | 5 | Current gain code, 0 to 17 |
| gain_top | output | 4 | Gain code divided by 2 |
| status | output | 8 | {5'b0, underflow, overflow, busy} |
| warn | output | 1 | Underflow OR overflow |

## Verification
A host write and a conversion beat can fall in the same cycle. The bench provokes this by raising `host_wr` on the same edge that offers an underflowing beat. It then checks three things. First, `smp_ready` reads low in that cycle. Second, after the edge the gain equals the written value and the flags are untouched. Third, one edge later the held beat is taken and steps one code up from the written gain. Saturation meeting a fault beat is the other overlap: a fault beat at code 0 or code 17 must set its flag without moving the code.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef struct packed {
    logic uflo;
    logic oflo;
  } fault_t;
endpackage

// File: rtl/agc_level_detect.sv
module agc_level_detect
  import agc_pkg::*;
#(
  parameter int N_CH   = 3,
  parameter int SMP_W  = 10,
  parameter int LO_THR = 256,
  parameter int HI_THR = 506
) (
  input  logic [N_CH*SMP_W-1:0] smp_data,
  output fault_t                flt
);
  localparam int MAG_W = SMP_W + 1;
  localparam logic [MAG_W-1:0] LO_V = MAG_W'(LO_THR);
  localparam logic [MAG_W-1:0] HI_V = MAG_W'(HI_THR);

  logic [N_CH-1:0] is_low;
  logic [N_CH-1:0] is_high;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic signed [SMP_W-1:0] s;
    logic signed [MAG_W-1:0] s_ext;
    logic        [MAG_W-1:0] mag;
    assign s     = smp_data[c*SMP_W +: SMP_W];
    assign s_ext = MAG_W'(s);
    assign mag   = s[SMP_W-1] ? MAG_W'(-s_ext) : MAG_W'(s_ext);
    assign is_low[c]  = (mag < LO_V);
    assign is_high[c] = (mag > HI_V);
  end

  assign flt.uflo = &is_low;
  assign flt.oflo = |is_high;
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step
  import agc_pkg::*;
#(
  parameter int GAIN_W   = 5,
  parameter int GAIN_MAX = 17
) (
  input  logic [GAIN_W-1:0] cur,
  input  fault_t            flt,
  output logic [GAIN_W-1:0] nxt
);
  localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(GAIN_MAX);

  always_comb begin
    nxt = cur;
    if (flt.oflo) begin
      if (cur != '0) nxt = cur - 1'b1;
    end else if (flt.uflo) begin
      if (cur < GMAX) nxt = cur + 1'b1;
    end
  end
endmodule

// File: rtl/agc_host_clip.sv
module agc_host_clip #(
  parameter int GAIN_W   = 5,
  parameter int GAIN_MAX = 17
) (
  input  logic [GAIN_W-1:0] raw,
  output logic [GAIN_W-1:0] clipped
);
  localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(GAIN_MAX);
  assign clipped = (raw > GMAX) ? GMAX : raw;
endmodule

// File: rtl/agc_stepper.sv
module agc_stepper
  import agc_pkg::*;
#(
  parameter int N_CH     = 3,
  parameter int SMP_W    = 10,
  parameter int GAIN_W   = 5,
  parameter int GAIN_MAX = 17,
  parameter int LO_THR   = 256,
  parameter int HI_THR   = 506
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  output logic                   smp_ready,
  input  logic [N_CH*SMP_W-1:0]  smp_data,
  input  logic                   agc_off,
  input  logic                   conv_busy,
  input  logic                   host_wr,
  input  logic [GAIN_W-1:0]      host_gain,
  output logic [GAIN_W-1:0]      gain_code,
  output logic [GAIN_W-2:0]      gain_top,
  output logic [7:0]             status,
  output logic                   warn
);
  localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(GAIN_MAX);

  fault_t            flt;
  fault_t            flags_q;
  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_step;
  logic [GAIN_W-1:0] host_clip;
  logic              acc;

  agc_level_detect #(
    .N_CH(N_CH), .SMP_W(SMP_W), .LO_THR(LO_THR), .HI_THR(HI_THR)
  ) u_det (
    .smp_data(smp_data),
    .flt     (flt)
  );

  agc_gain_step #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_step (
    .cur(gain_q),
    .flt(flt),
    .nxt(gain_step)
  );

  agc_host_clip #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_clip (
    .raw    (host_gain),
    .clipped(host_clip)
  );

  // a host write owns the gain register for one cycle, so beats wait
  assign smp_ready = rst_n & ~host_wr;
  assign acc       = smp_valid & smp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= '0;
      flags_q <= '0;
    end else begin
      if (host_wr) begin
        gain_q <= host_clip;
      end else if (acc) begin
        flags_q <= flt;
        if (!agc_off) gain_q <= gain_step;
      end
    end
  end

  assign gain_code = gain_q;
  assign gain_top  = gain_q[GAIN_W-1:1];
  assign status    = {5'b0, flags_q.uflo, flags_q.oflo, conv_busy};
  assign warn      = flags_q.uflo | flags_q.oflo;

  AST_GAIN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GMAX); // R5
  AST_UFLO_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && flt.uflo && !flt.oflo && !agc_off && gain_q != GMAX)
      |=> (gain_q == $past(gain_q) + 1'b1) && status[2]); // R2
  AST_OFLO_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && flt.oflo && !agc_off && gain_q != '0)
      |=> (gain_q == $past(gain_q) - 1'b1) && status[1]); // R3
  AST_AGC_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && agc_off) |=> $stable(gain_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !host_wr) |=> $stable(gain_q) && $stable(status[2:1])); // R11
  AST_WRITE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> $stable(status[2:1])); // R8
endmodule

// File: tb/sim_agc_stepper.sv
`timescale 1ns/1ps
module sim_agc_stepper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [29:0] smp_data = '0;
  logic        agc_off = 1'b0;
  logic        conv_busy = 1'b0;
  logic        host_wr = 1'b0;
  logic [4:0]  host_gain = '0;
  logic [4:0]  gain_code;
  logic [3:0]  gain_top;
  logic [7:0]  status;
  logic        warn;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agc_stepper u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .agc_off(agc_off), .conv_busy(conv_busy),
    .host_wr(host_wr), .host_gain(host_gain), .gain_code(gain_code),
    .gain_top(gain_top), .status(status), .warn(warn)
  );

  typedef struct packed {
    logic signed [9:0] a;
    logic signed [9:0] b;
    logic signed [9:0] c;
    logic              off;
    logic [4:0]        g;
    logic [7:0]        st;
  } vec_t;

  // walked from the reset gain of 0; g and st are expected after the beat
  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{10'sd0,    10'sd0,    10'sd0,   1'b0, 5'd1, 8'h04}, // R2 all low
    '{10'sd100, -10'sd200,  10'sd255, 1'b0, 5'd2, 8'h04}, // R2 255 still low
    '{10'sd256,  10'sd0,    10'sd0,   1'b0, 5'd2, 8'h00}, // R4 256 in range
    '{10'sd506, -10'sd506,  10'sd0,   1'b0, 5'd2, 8'h00}, // R4 506 in range
    '{10'sd507,  10'sd0,    10'sd0,   1'b0, 5'd1, 8'h02}, // R3 one high
    '{-10'sd512, 10'sd0,    10'sd0,   1'b0, 5'd0, 8'h02}, // R3 most negative
    '{-10'sd507, 10'sd0,    10'sd0,   1'b0, 5'd0, 8'h02}, // R5 floor
    '{10'sd0,    10'sd0,   -10'sd300, 1'b0, 5'd0, 8'h00}, // R4 one mid
    '{-10'sd255, 10'sd255,  10'sd0,   1'b1, 5'd0, 8'h04}, // R6 off, uflo
    '{10'sd508,  10'sd0,    10'sd0,   1'b1, 5'd0, 8'h02}, // R6 off, oflo
    '{10'sd10,   10'sd10,   10'sd10,  1'b0, 5'd1, 8'h04}  // R2 back on
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [29:0] pack3(input logic signed [9:0] a,
                                        input logic signed [9:0] b,
                                        input logic signed [9:0] c);
    return {c, b, a};
  endfunction

  task automatic beat(input logic [29:0] d, input logic off);
    @(negedge clk);
    smp_data  = d;
    agc_off   = off;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic hwrite(input logic [4:0] v);
    @(negedge clk);
    host_gain = v;
    host_wr   = 1'b1;
    @(negedge clk);
    host_wr   = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gain_code", gain_code, 0);
    chk("R1 gain_top", gain_top, 0);
    chk("R1 status", status, 0);
    chk("R1 warn", warn, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ready idle", smp_ready, 1);

    for (int i = 0; i < NV; i++) begin
      beat(pack3(TBL[i].a, TBL[i].b, TBL[i].c), TBL[i].off);
      chk($sformatf("R2-table gain v%0d", i), gain_code, TBL[i].g);
      chk($sformatf("R3-table status v%0d", i), status, TBL[i].st);
      chk($sformatf("R9 warn v%0d", i), warn, (TBL[i].st[2] | TBL[i].st[1]));
    end

    // R11: valid low with an overflowing pattern changes nothing
    @(negedge clk);
    smp_data = pack3(10'sd510, 10'sd510, 10'sd510);
    repeat (3) @(negedge clk);
    chk("R11 gain hold", gain_code, 1);
    chk("R11 flags hold", status, 8'h04);

    // R7: write with stepping off, then clipping
    agc_off = 1'b1;
    hwrite(5'd9);
    chk("R7 host load", gain_code, 9);
    chk("R10 top of 9", gain_top, 4);
    agc_off = 1'b0;
    hwrite(5'd31);
    chk("R7 clip 31", gain_code, 17);
    chk("R10 top of 17", gain_top, 8);

    // R5: ceiling holds under underflow, flag still set
    beat(pack3(10'sd1, 10'sd2, 10'sd3), 1'b0);
    chk("R5 ceiling gain", gain_code, 17);
    chk("R5 ceiling flag", status, 8'h04);

    // R8: write and beat in the same cycle
    beat(pack3(10'sd509, 10'sd0, 10'sd0), 1'b0); // gain 16, oflo
    chk("R3 down from 17", gain_code, 16);
    @(negedge clk);
    smp_data  = pack3(10'sd5, 10'sd5, 10'sd5);
    smp_valid = 1'b1;
    host_gain = 5'd12;
    host_wr   = 1'b1;
    #1;
    chk("R8 ready low on write", smp_ready, 0);
    @(negedge clk);
    chk("R8 write wins", gain_code, 12);
    chk("R8 flags untouched", status, 8'h02);
    host_wr = 1'b0;
    #1;
    chk("R8 ready back", smp_ready, 1);
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R8 held beat steps", gain_code, 13);
    chk("R8 held beat flag", status, 8'h04);

    // R9: busy bit passes straight through
    conv_busy = 1'b1;
    #1;
    chk("R9 busy bit", status, 8'h05);
    chk("R9 warn", warn, 1);
    conv_busy = 1'b0;

    // R1: reset again in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 re-reset gain", gain_code, 0);
    chk("R1 re-reset warn", warn, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule